// File: doc/BRIEF.md
# Two-Channel Fetch-Store DMA Controller

This block moves data on a shared bus on behalf of two independent channels. Every transfer is done in two steps. First the block reads an item from the source into an internal holding register. Then it writes that register to the destination. The source and the destination may each be in memory space or in I/O space, so all four combinations of the two spaces are legal. A channel moves either bytes or 16-bit words. A word at an odd address is split into two byte cycles.

Software programs each channel through a small register port. Each channel has a source pointer, a destination pointer, a transfer count and a control word. A channel runs when its enable bit is set and, if it is in external-trigger mode, when its request line is high. The block shares the bus with a processor. It has a simple request/grant pair on the processor side. A pending DMA transfer wins the bus over the processor. When both channels are ready, they take turns on a per-transfer basis.

Top module: `dual_xfer_dma`

## Requirements
- R1: After reset, `bus_valid`, `cpu_gnt` and `irq` are low, and every register reads as zero.
- R2: Each transfer is one read (or read pair) followed by one write (or write pair). The written value is the value that was read. A byte is fetched on `bus_rdata[7:0]` and stored on `bus_wdata[7:0]`, with the upper byte zero.
- R3: A bus cycle keeps `bus_valid` high, with address, direction, space and size stable, for at least 4 clocks. It ends at the first clock, from the 4th onward, in which `bus_ready` is high.
- R4: Control bit 2 places the source in I/O space and control bit 3 places the destination in I/O space. `bus_io` follows the side being accessed.
- R5: Control bit 1 selects word size. A word access at an even address is a single cycle with `bus_word` high, and the data is on all 16 bits.
- R6: A word access at an odd address A is split into two byte cycles: A carrying the low byte, then A+1 carrying the high byte. The fetched byte pair is stored again as a 16-bit value.
- R7: After each transfer, each pointer moves by its own 2-bit field: control bits 5:4 for the source and 7:6 for the destination. 01 increments, 10 decrements, and 00 or 11 holds. The step is 2 in word mode and 1 in byte mode.
- R8: The count drops by one after each store. When it reaches zero, control bit 0 (enable) clears and no further cycles run. A channel enabled with a count of zero runs nothing.
- R9: When the count reaches zero and control bit 8 is set, `irq[ch]` pulses high for exactly one clock. With bit 8 clear, no pulse occurs.
- R10: With control bit 9 set, a channel starts transfers only while `dreq[ch]` is high. Otherwise no bus cycle runs and its registers keep their values.
- R11: `cpu_gnt` and `bus_valid` are never high together. When a channel is ready while the bus is free, DMA takes the bus even if `cpu_req` is high. A granted processor keeps the bus until it drops `cpu_req`.
- R12: When both channels are ready, transfers alternate, starting with the channel that was not served last.
- R13: Register select: 0 is the source pointer, 1 the destination pointer, 2 the count and 3 the control word. Writes are addressed by `reg_ch`/`reg_sel`, and `reg_rdata` returns the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel addressed by the register port |
| reg_sel | input | 2 | Register select within the channel |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Selected register contents |
| dreq | input | 2 | Per-channel external transfer request |
| irq | output | 2 | Per-channel terminal-count pulse |
| cpu_req | input | 1 | Processor bus request |
| cpu_gnt | output | 1 | Processor bus grant |
| bus_valid | output | 1 | DMA bus cycle active |
| bus_write | output | 1 | 1 = store cycle, 0 = fetch cycle |
| bus_io | output | 1 | 1 = I/O space, 0 = memory space |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 16 | Store data |
| bus_rdata | input | 16 | Fetch data |
| bus_ready | input | 1 | Cycle may end this clock |

## Verification
Some properties are checked on every clock:
- The processor grant and a DMA cycle never overlap.
- A bus cycle keeps its address and attributes stable until its fourth clock with ready.
- A burst of DMA activity always opens with a fetch.
- Terminal-count pulses last one clock and follow a completed store.

Other behaviour can only be shown by the bench's scenarios, which compare every bus cycle against an independently built expected list:
- the values moved between spaces;
- the split of odd-address words and the order of their bytes;
- pointer stepping and count exhaustion;
- the per-transfer turn-taking between channels;
- the effect of the trigger lines.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
   localparam int NCH    = 2;
   localparam int CTRL_W = 10;

   // control word bit positions
   localparam int CB_EN    = 0;
   localparam int CB_WORD  = 1;
   localparam int CB_SIO   = 2;
   localparam int CB_DIO   = 3;
   localparam int CB_SSTEP = 4;
   localparam int CB_DSTEP = 6;
   localparam int CB_IRQ   = 8;
   localparam int CB_EXT   = 9;

   localparam logic [1:0] STEP_INC = 2'b01;
   localparam logic [1:0] STEP_DEC = 2'b10;

   localparam logic [1:0] SEL_SRC  = 2'd0;
   localparam logic [1:0] SEL_DST  = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   typedef enum logic [2:0] {PH_IDLE, PH_RD0, PH_RD1, PH_WR0, PH_WR1} phase_t;
   typedef enum logic [1:0] {OWN_NONE, OWN_DMA, OWN_CPU} owner_t;
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
   import dma_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              dreq,
   input  logic              xfer_done,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [CNT_W-1:0]  cnt,
   output logic [CTRL_W-1:0] ctrl,
   output logic              ready,
   output logic              irq,
   output logic [ADDR_W-1:0] rd_data
);
   logic unused_hi;
   assign unused_hi = ^wr_data[ADDR_W-1:CTRL_W];

   function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] mode,
                                                 input logic word);
      logic [ADDR_W-1:0] sz;
      sz = word ? ADDR_W'(2) : ADDR_W'(1);
      case (mode)
         STEP_INC: return a + sz;
         STEP_DEC: return a - sz;
         default:  return a;
      endcase
   endfunction

   assign ready = ctrl[CB_EN] && (cnt != '0) && (!ctrl[CB_EXT] || dreq);

   always_comb begin
      case (wr_sel)
         SEL_SRC: rd_data = src;
         SEL_DST: rd_data = dst;
         SEL_CNT: rd_data = ADDR_W'(cnt);
         default: rd_data = ADDR_W'(ctrl);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
         ctrl <= '0;
         irq  <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (xfer_done) begin
            src <= advance(src, ctrl[CB_SSTEP +: 2], ctrl[CB_WORD]);
            dst <= advance(dst, ctrl[CB_DSTEP +: 2], ctrl[CB_WORD]);
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
               ctrl[CB_EN] <= 1'b0;
               irq         <= ctrl[CB_IRQ];
            end
         end
         if (wr_en) begin
            case (wr_sel)
               SEL_SRC: src  <= wr_data;
               SEL_DST: dst  <= wr_data;
               SEL_CNT: cnt  <= wr_data[CNT_W-1:0];
               default: ctrl <= wr_data[CTRL_W-1:0];
            endcase
         end
      end
   end
endmodule

// File: rtl/dma_rr_arb.sv
`timescale 1ns/1ps
module dma_rr_arb
   import dma_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] ready,
   input  logic           eng_idle,
   input  logic           xfer_done,
   input  logic           start,
   input  logic           cpu_req,
   output logic           cpu_gnt,
   output logic           dma_own,
   output logic           pick
);
   owner_t owner;
   logic   last;

   // the channel not served last goes first when both are ready
   assign pick    = ready[~last] ? ~last : last;
   assign cpu_gnt = (owner == OWN_CPU);
   assign dma_own = (owner == OWN_DMA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner <= OWN_NONE;
         last  <= 1'b1;
      end else begin
         if (start) last <= pick;
         case (owner)
            OWN_NONE: begin
               if (|ready)       owner <= OWN_DMA;
               else if (cpu_req) owner <= OWN_CPU;
            end
            OWN_DMA: begin
               if (xfer_done || (eng_idle && !(|ready))) owner <= OWN_NONE;
            end
            default: begin
               if (!cpu_req) owner <= OWN_NONE;
            end
         endcase
      end
   end
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
   import dma_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int BUS_MIN_CLK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_ch,
   input  logic [ADDR_W-1:0] src_in,
   input  logic [ADDR_W-1:0] dst_in,
   input  logic              word_in,
   input  logic              sio_in,
   input  logic              dio_in,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ready,
   output logic              idle,
   output logic              done,
   output logic              done_ch,
   output logic              bus_valid,
   output logic              bus_write,
   output logic              bus_io,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata
);
   localparam int TICK_W = $clog2(BUS_MIN_CLK);
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(BUS_MIN_CLK - 1);

   phase_t            phase;
   logic [TICK_W-1:0] tick;
   logic [ADDR_W-1:0] s_q, d_q;
   logic              word_q, sio_q, dio_q;
   logic [15:0]       hold;
   logic              end_ok, s_split, d_split;

   assign s_split   = word_q && s_q[0];
   assign d_split   = word_q && d_q[0];
   assign end_ok    = (tick == TICK_LAST) && bus_ready;
   assign idle      = (phase == PH_IDLE);
   assign bus_valid = !idle;
   assign bus_write = (phase == PH_WR0) || (phase == PH_WR1);
   assign bus_io    = bus_write ? dio_q : sio_q;
   assign done      = end_ok && (((phase == PH_WR0) && !d_split) || (phase == PH_WR1));

   always_comb begin
      bus_addr  = '0;
      bus_word  = 1'b0;
      bus_wdata = '0;
      case (phase)
         PH_RD0: begin bus_addr = s_q; bus_word = word_q && !s_q[0]; end
         PH_RD1: bus_addr = s_q + ADDR_W'(1);
         PH_WR0: begin
            bus_addr  = d_q;
            bus_word  = word_q && !d_q[0];
            bus_wdata = bus_word ? hold : {8'h00, hold[7:0]};
         end
         PH_WR1: begin bus_addr = d_q + ADDR_W'(1); bus_wdata = {8'h00, hold[15:8]}; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         tick    <= '0;
         s_q     <= '0;
         d_q     <= '0;
         word_q  <= 1'b0;
         sio_q   <= 1'b0;
         dio_q   <= 1'b0;
         hold    <= '0;
         done_ch <= 1'b0;
      end else if (idle) begin
         tick <= '0;
         if (start) begin
            phase   <= PH_RD0;
            s_q     <= src_in;
            d_q     <= dst_in;
            word_q  <= word_in;
            sio_q   <= sio_in;
            dio_q   <= dio_in;
            done_ch <= start_ch;
         end
      end else if (end_ok) begin
         tick <= '0;
         case (phase)
            PH_RD0: begin
               if (s_split) begin
                  hold[7:0] <= bus_rdata[7:0];
                  phase     <= PH_RD1;
               end else begin
                  hold  <= word_q ? bus_rdata : {8'h00, bus_rdata[7:0]};
                  phase <= PH_WR0;
               end
            end
            PH_RD1: begin
               hold[15:8] <= bus_rdata[7:0];
               phase      <= PH_WR0;
            end
            PH_WR0:  phase <= d_split ? PH_WR1 : PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end else if (tick != TICK_LAST) begin
         tick <= tick + TICK_W'(1);
      end
   end
endmodule

// File: rtl/dual_xfer_dma.sv
`timescale 1ns/1ps
module dual_xfer_dma
   import dma_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int CNT_W       = 16,
   parameter int BUS_MIN_CLK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_ch,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [1:0]        dreq,
   output logic [1:0]        irq,
   input  logic              cpu_req,
   output logic              cpu_gnt,
   output logic              bus_valid,
   output logic              bus_write,
   output logic              bus_io,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ready
);
   if (ADDR_W < CNT_W || ADDR_W < CTRL_W) begin : g_bad_width
      $error("ADDR_W must hold the count and control word");
   end
   if (BUS_MIN_CLK < 2) begin : g_bad_min
      $error("BUS_MIN_CLK must be at least 2");
   end
   if (NCH != 2) begin : g_bad_nch
      $error("turn-taking logic is built for two channels");
   end

   logic [ADDR_W-1:0] c_src [NCH];
   logic [ADDR_W-1:0] c_dst [NCH];
   logic [ADDR_W-1:0] c_rd  [NCH];
   logic [CNT_W-1:0]  c_cnt [NCH];
   logic [CTRL_W-1:0] c_ctrl[NCH];
   logic [NCH-1:0]    c_rdy, c_done, c_irq;
   logic              eng_idle, eng_done, eng_ch, dma_own, pick, start;
   logic              unused_cnt;

   assign start      = dma_own && eng_idle && (|c_rdy);
   assign reg_rdata  = c_rd[reg_ch];
   assign irq        = c_irq;
   assign unused_cnt = ^{c_cnt[0], c_cnt[1]};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      assign c_done[ch] = eng_done && (eng_ch == 1'(ch));
      dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (reg_we && (reg_ch == 1'(ch))),
         .wr_sel   (reg_sel),
         .wr_data  (reg_wdata),
         .dreq     (dreq[ch]),
         .xfer_done(c_done[ch]),
         .src      (c_src[ch]),
         .dst      (c_dst[ch]),
         .cnt      (c_cnt[ch]),
         .ctrl     (c_ctrl[ch]),
         .ready    (c_rdy[ch]),
         .irq      (c_irq[ch]),
         .rd_data  (c_rd[ch])
      );
   end

   dma_rr_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (c_rdy),
      .eng_idle (eng_idle),
      .xfer_done(eng_done),
      .start    (start),
      .cpu_req  (cpu_req),
      .cpu_gnt  (cpu_gnt),
      .dma_own  (dma_own),
      .pick     (pick)
   );

   dma_xfer_engine #(.ADDR_W(ADDR_W), .BUS_MIN_CLK(BUS_MIN_CLK)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_ch (pick),
      .src_in   (c_src[pick]),
      .dst_in   (c_dst[pick]),
      .word_in  (c_ctrl[pick][CB_WORD]),
      .sio_in   (c_ctrl[pick][CB_SIO]),
      .dio_in   (c_ctrl[pick][CB_DIO]),
      .bus_rdata(bus_rdata),
      .bus_ready(bus_ready),
      .idle     (eng_idle),
      .done     (eng_done),
      .done_ch  (eng_ch),
      .bus_valid(bus_valid),
      .bus_write(bus_write),
      .bus_io   (bus_io),
      .bus_word (bus_word),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata)
   );
endmodule

// File: rtl/dma_checks.sv
`timescale 1ns/1ps
module dma_checks #(
   parameter int ADDR_W      = 20,
   parameter int BUS_MIN_CLK = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_gnt,
   input logic              bus_valid,
   input logic              bus_write,
   input logic              bus_io,
   input logic              bus_word,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_ready,
   input logic [1:0]        irq
);
   localparam int SW = $clog2(BUS_MIN_CLK) + 1;
   logic [SW-1:0] seg;
   logic          seg_end;

   assign seg_end = bus_valid && bus_ready && (seg == SW'(BUS_MIN_CLK - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                                       seg <= '0;
      else if (seg_end || !bus_valid)                   seg <= '0;
      else if (seg != SW'(BUS_MIN_CLK - 1))             seg <= seg + SW'(1);
   end

   a_r11_no_share: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_gnt && bus_valid));

   a_r3_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_valid) && !$past(seg_end)) |->
         (bus_valid && $stable(bus_addr) && $stable(bus_write) &&
          $stable(bus_io) && $stable(bus_word)));

   a_r2_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_valid) |-> !bus_write);

   a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |=> (irq == 2'b00));

   a_r8_irq_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq) |-> $past(bus_valid && bus_write && bus_ready));
endmodule

bind dual_xfer_dma dma_checks #(.ADDR_W(ADDR_W), .BUS_MIN_CLK(BUS_MIN_CLK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_gnt  (cpu_gnt),
   .bus_valid(bus_valid),
   .bus_write(bus_write),
   .bus_io   (bus_io),
   .bus_word (bus_word),
   .bus_addr (bus_addr),
   .bus_ready(bus_ready),
   .irq      (irq)
);

// File: tb/sim_dual_xfer_dma.sv
`timescale 1ns/1ps
module sim_dual_xfer_dma;
   localparam int AW = 20;

   typedef struct packed {
      logic          w;
      logic          io;
      logic          word;
      logic [AW-1:0] addr;
      logic [15:0]   data;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic          reg_ch = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic [1:0]    dreq = 2'b00;
   logic [1:0]    irq;
   logic          cpu_req = 1'b0;
   logic          cpu_gnt;
   logic          bus_valid, bus_write, bus_io, bus_word;
   logic [AW-1:0] bus_addr;
   logic [15:0]   bus_wdata, bus_rdata;
   logic          bus_ready = 1'b1;

   int checks = 0, errors = 0, completions = 0, run = 0, cycles = 0;
   int irq_cnt [2];
   bit finished = 1'b0;
   item_t exp_q[$];

   logic [AW-1:0] b_src [2];
   logic [AW-1:0] b_dst [2];
   logic [19:0]   b_ctl [2];
   logic          b_last = 1'b1;

   always #10 clk = ~clk;

   dual_xfer_dma u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .irq(irq),
      .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_io(bus_io), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   function automatic logic [7:0] mb(input logic io, input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ (io ? 8'hA5 : 8'h3C);
   endfunction

   always_comb
      bus_rdata = bus_word ? {mb(bus_io, bus_addr + 1), mb(bus_io, bus_addr)}
                           : {8'h00, mb(bus_io, bus_addr)};

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard at each completed bus cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq[0]) irq_cnt[0]++;
         if (irq[1]) irq_cnt[1]++;
         if (cpu_gnt && bus_valid) check(0, "R11 grant overlaps dma cycle", 1, 0);
         if (bus_valid) begin
            run++;
            if (run >= 4 && bus_ready) begin
               item_t got, exp;
               got = '{w: bus_write, io: bus_io, word: bus_word, addr: bus_addr,
                       data: bus_write ? bus_wdata : bus_rdata};
               completions++;
               run = 0;
               if (exp_q.size() == 0) check(0, "R2 unexpected bus cycle", 64'(got), 0);
               else begin
                  exp = exp_q.pop_front();
                  check(got == exp, "R2/R4/R5/R6 bus cycle", 64'(got), 64'(exp));
               end
            end
         end else run = 0;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(0, "watchdog expired", cycles, 150000);
         finish_up();
      end
   end

   function automatic logic [19:0] mk_ctl(input bit en, word, sio, dio, input logic [1:0] ss, ds,
                                          input bit ie, ext);
      return {10'b0, ext, ie, ds, ss, dio, sio, word, en};
   endfunction

   function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m, input bit word);
      logic [AW-1:0] s = word ? 2 : 1;
      return (m == 2'b01) ? a + s : (m == 2'b10) ? a - s : a;
   endfunction

   task automatic wr(input logic ch, input logic [1:0] sel, input logic [AW-1:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic ch, input logic [1:0] sel, output logic [AW-1:0] v);
      @(posedge clk); #1;
      reg_ch = ch; reg_sel = sel;
      #2 v = reg_rdata;
   endtask

   // driver: program a channel; the control write goes last
   task automatic prog(input logic ch, input logic [AW-1:0] s, d, input int n, input logic [19:0] c);
      b_src[ch] = s; b_dst[ch] = d; b_ctl[ch] = c;
      wr(ch, 2'd0, s);
      wr(ch, 2'd1, d);
      wr(ch, 2'd2, AW'(n));
      wr(ch, 2'd3, c);
   endtask

   // driver: push the bus cycles one transfer of channel ch must produce
   task automatic expect_xfer(input logic ch);
      logic          word, sio, dio;
      logic [AW-1:0] s, d;
      logic [15:0]   v;
      word = b_ctl[ch][1]; sio = b_ctl[ch][2]; dio = b_ctl[ch][3];
      s = b_src[ch]; d = b_dst[ch];
      v = {mb(sio, s + 1), mb(sio, s)};
      if (!word) begin
         v = {8'h00, mb(sio, s)};
         exp_q.push_back('{0, sio, 0, s, v});
         exp_q.push_back('{1, dio, 0, d, v});
      end else begin
         if (!s[0]) exp_q.push_back('{0, sio, 1, s, v});
         else begin
            exp_q.push_back('{0, sio, 0, s,     {8'h00, v[7:0]}});
            exp_q.push_back('{0, sio, 0, s + 1, {8'h00, v[15:8]}});
         end
         if (!d[0]) exp_q.push_back('{1, dio, 1, d, v});
         else begin
            exp_q.push_back('{1, dio, 0, d,     {8'h00, v[7:0]}});
            exp_q.push_back('{1, dio, 0, d + 1, {8'h00, v[15:8]}});
         end
      end
      b_src[ch] = step(s, b_ctl[ch][5:4], word);
      b_dst[ch] = step(d, b_ctl[ch][7:6], word);
      b_last = ch;
   endtask

   task automatic wait_quiet();
      int t = 0;
      while ((exp_q.size() != 0 || bus_valid) && t < 3000) begin @(negedge clk); t++; end
      repeat (6) @(negedge clk);
      check(exp_q.size() == 0 && !bus_valid, "R2 expected cycles outstanding", exp_q.size(), 0);
   endtask

   task automatic end_state(input logic ch, input string tag);
      logic [AW-1:0] v;
      rd(ch, 2'd0, v); check(v == b_src[ch], {tag, " source pointer"}, v, b_src[ch]);
      rd(ch, 2'd1, v); check(v == b_dst[ch], {tag, " dest pointer"}, v, b_dst[ch]);
      rd(ch, 2'd2, v); check(v == 0, "R8 count exhausted", v, 0);
      rd(ch, 2'd3, v); check(v[0] == 1'b0, "R8 enable cleared", v[0], 0);
   endtask

   initial begin
      logic [AW-1:0] v;
      int base, t;
      irq_cnt[0] = 0; irq_cnt[1] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!bus_valid, "R1 bus_valid after reset", bus_valid, 0);
      check(!cpu_gnt, "R1 cpu_gnt after reset", cpu_gnt, 0);
      check(irq == 2'b00, "R1 irq after reset", irq, 0);
      for (int ch = 0; ch < 2; ch++)
         for (int s = 0; s < 4; s++) begin
            rd(ch[0], s[1:0], v);
            check(v == 0, "R1 R13 register reset value", v, 0);
         end

      // byte, memory to I/O, source up, destination fixed, interrupt on
      prog(0, 20'h01000, 20'h00300, 3, mk_ctl(1, 0, 0, 1, 2'b01, 2'b00, 1, 0));
      repeat (3) expect_xfer(0);
      wait_quiet();
      end_state(0, "R7 byte");
      check(irq_cnt[0] == 1, "R9 single pulse at terminal count", irq_cnt[0], 1);

      // even words, I/O to memory, source down, destination up, no interrupt
      prog(1, 20'h00400, 20'h08000, 2, mk_ctl(1, 1, 1, 0, 2'b10, 2'b01, 0, 0));
      repeat (2) expect_xfer(1);
      wait_quiet();
      end_state(1, "R5 R7 word");
      check(irq_cnt[1] == 0, "R9 no pulse with bit 8 clear", irq_cnt[1], 0);

      // odd words both sides, memory to memory, split cycles
      prog(0, 20'h00101, 20'h02003, 2, mk_ctl(1, 1, 0, 0, 2'b01, 2'b01, 0, 0));
      repeat (2) expect_xfer(0);
      wait_quiet();
      end_state(0, "R6 odd word");

      // external trigger: held off while dreq low, then both channels alternate
      base = completions;
      prog(0, 20'h03000, 20'h00010, 3, mk_ctl(1, 0, 0, 1, 2'b01, 2'b11, 0, 1));
      prog(1, 20'h00020, 20'h04000, 3, mk_ctl(1, 0, 1, 0, 2'b11, 2'b01, 0, 1));
      repeat (40) @(negedge clk);
      check(completions == base, "R10 no cycles while dreq low", completions - base, 0);
      rd(0, 2'd2, v); check(v == 3, "R10 count untouched while dreq low", v, 3);
      for (int k = 0; k < 3; k++) begin
         expect_xfer(~b_last);
         expect_xfer(~b_last);
      end
      @(posedge clk); #1 dreq = 2'b11;
      wait_quiet();
      end_state(0, "R12 ch0");
      end_state(1, "R12 ch1");
      @(posedge clk); #1 dreq = 2'b00;

      // wait states stretch a cycle
      @(posedge clk); #1 bus_ready = 1'b0;
      base = completions;
      prog(1, 20'h00555, 20'h00666, 1, mk_ctl(1, 0, 0, 0, 2'b00, 2'b00, 0, 0));
      expect_xfer(1);
      repeat (20) @(negedge clk);
      check(bus_valid && !bus_write && bus_addr == 20'h00555, "R3 cycle held while not ready",
            {bus_valid, bus_write, bus_addr}, {2'b10, 20'h00555});
      check(completions == base, "R3 no completion while not ready", completions - base, 0);
      @(posedge clk); #1 bus_ready = 1'b1;
      wait_quiet();

      // processor holds the bus; DMA waits
      @(posedge clk); #1 cpu_req = 1'b1;
      repeat (4) @(negedge clk);
      check(cpu_gnt, "R11 processor granted on free bus", cpu_gnt, 1);
      base = completions;
      prog(0, 20'h00700, 20'h00800, 1, mk_ctl(1, 0, 0, 0, 2'b01, 2'b01, 0, 0));
      repeat (20) @(negedge clk);
      check(!bus_valid && completions == base, "R11 granted processor keeps bus",
            completions - base, 0);
      expect_xfer(0);
      @(posedge clk); #1 cpu_req = 1'b0;
      wait_quiet();

      // DMA and processor request together: DMA wins
      prog(0, 20'h00900, 20'h00A00, 1, mk_ctl(1, 0, 0, 0, 2'b01, 2'b01, 0, 0));
      #0 cpu_req = 1'b1;
      expect_xfer(0);
      t = 0;
      while (!bus_valid && t < 100) begin @(negedge clk); t++; end
      check(bus_valid && !cpu_gnt, "R11 DMA wins simultaneous request", cpu_gnt, 0);
      wait_quiet();
      check(cpu_gnt, "R11 processor granted after DMA", cpu_gnt, 1);
      @(posedge clk); #1 cpu_req = 1'b0;

      // zero count runs nothing
      base = completions;
      wr(1, 2'd2, '0);
      wr(1, 2'd3, mk_ctl(1, 0, 0, 0, 2'b01, 2'b01, 1, 0));
      repeat (30) @(negedge clk);
      check(completions == base && !bus_valid, "R8 zero count starts nothing", completions - base, 0);
      check(irq_cnt[1] == 0, "R9 no pulse for zero count", irq_cnt[1], 0);

      finish_up();
   end
endmodule